// File: doc/BRIEF.md
# Programmable Short-Pulse Clock Pattern Generator

This block produces a test clock from a fast sample clock. The generated clock is a train of fixed-length windows, each a whole number of sample ticks long. An ordinary window holds the clock low for its first half and raises it at the midpoint, which gives a 50% duty clock. In one chosen window the block swaps in a glitch window. That window carries two consecutive narrow pulses just ahead of the midpoint rising edge, so the circuit downstream sees extra clock edges that are much faster than its normal period.

Both window types are described as short lists of timed edges. Each list entry holds a tick position and a direction (rise or fall). A small engine plays back the list that belongs to the current window. The narrow-pulse width is a register value. A test sequence sweeps it from run to run to find the width at which the downstream logic starts to fail. A start pulse latches the configuration and begins window 0. A marker output stays high for exactly the samples that belong to the substituted window. The block has no data stream, so every pin is a plain control or status signal.

Top module: `pulse_window_clkgen`

## Requirements
- R1: After reset, and at all times before the first start pulse, `clk_gen` and `glitch_active` are both 0.
- R2: The output is registered. The value for global tick g (g = 0 is tick 0 of window 0) appears on `clk_gen` in the (g+1)-th sample-clock cycle after the edge that samples `start` high.
- R3: A normal window of effective length Le is 0 for ticks 0 .. floor(Le/2)-1 and 1 for ticks floor(Le/2) .. Le-1.
- R4: With M = floor(Le/2) and effective width Te, the glitch window is 1 on ticks [M-4Te, M-3Te) and [M-2Te, M-Te) and on ticks M .. Le-1, and 0 on all its other ticks. This forms two pulses of width Te separated by Te, followed by the normal rise at M.
- R5: The effective pulse width Te is `pulse_width` clamped to the range [2, floor((M-1)/4)].
- R6: The effective window length Le is `win_len`, raised to 20 when it is smaller than 20.
- R7: The glitch window is used in exactly one window, the one whose index equals `glitch_cycle` (counting from 0 at start). Every later window is normal, including after the window counter would otherwise wrap.
- R8: `glitch_active` is 1 on exactly the Le output samples that belong to the glitch window, aligned with `clk_gen`.
- R9: The configuration is captured on start. Changing `win_len`, `pulse_width` or `glitch_cycle` during a run has no effect. A new start pulse, even in the middle of a run, restarts at window 0 with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and begin window 0 |
| win_len | input | WIN_W (8) | Window length in sample ticks |
| pulse_width | input | WIN_W (8) | Narrow-pulse width in ticks |
| glitch_cycle | input | CYC_W (4) | Index of the window to replace |
| clk_gen | output | 1 | Generated clock |
| glitch_active | output | 1 | High during the glitch window's samples |

## Verification
The checker watches several properties on every cycle:
- the outputs stay low while the generator is idle;
- the marker never stays high for longer than one window;
- the marker rises at most once per run;
- no more than three clock rises occur inside the marker window;
- the effective length and width always sit inside their clamp ranges.

Only the bench's scenarios can show the exact tick at which every edge falls. The bench compares each output sample with an arithmetic model of the pulse positions, across a sweep of lengths, widths and target indices. It also covers mid-run configuration changes and restarts, which need a reference to compare against.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  // Direction of one programmed edge
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;

  // Edges in the glitch window: rise, fall, rise, fall, then the midpoint rise
  localparam int unsigned GLT_EDGES = 5;
  // Edges in a normal window: the midpoint rise only
  localparam int unsigned NRM_EDGES = 1;
endpackage

// File: rtl/cpg_window_composer.sv
module cpg_window_composer
  import cpg_pkg::*;
#(
  parameter int unsigned WIN_W     = 8,
  parameter int unsigned MAX_EDGES = 8,
  parameter int unsigned LEN_MIN   = 20
) (
  input  logic [WIN_W-1:0]                  len_raw,
  input  logic [WIN_W-1:0]                  t_raw,
  output logic [WIN_W-1:0]                  len_eff,
  output logic [WIN_W-1:0]                  half,
  output logic [WIN_W-1:0]                  t_eff,
  output logic [MAX_EDGES-1:0][WIN_W-1:0]   nrm_tick,
  output logic [MAX_EDGES-1:0]              nrm_rise,
  output logic [MAX_EDGES-1:0]              nrm_vld,
  output logic [MAX_EDGES-1:0][WIN_W-1:0]   glt_tick,
  output logic [MAX_EDGES-1:0]              glt_rise,
  output logic [MAX_EDGES-1:0]              glt_vld
);
  localparam logic [WIN_W-1:0] LMIN  = WIN_W'(LEN_MIN);
  localparam logic [WIN_W-1:0] TMIN  = WIN_W'(2);

  logic [WIN_W-1:0] t_max;

  assign len_eff = (len_raw < LMIN) ? LMIN : len_raw;
  assign half    = len_eff >> 1;
  assign t_max   = (half - WIN_W'(1)) >> 2;
  assign t_eff   = (t_raw < TMIN) ? TMIN : ((t_raw > t_max) ? t_max : t_raw);

  for (genvar i = 0; i < MAX_EDGES; i++) begin : g_slot
    if (i < NRM_EDGES) begin : g_nrm_on
      assign nrm_tick[i] = half;
      assign nrm_rise[i] = EDGE_RISE;
      assign nrm_vld[i]  = 1'b1;
    end else begin : g_nrm_off
      assign nrm_tick[i] = '0;
      assign nrm_rise[i] = EDGE_FALL;
      assign nrm_vld[i]  = 1'b0;
    end

    if (i < GLT_EDGES) begin : g_glt_on
      // slot i sits (GLT_EDGES-1-i) pulse widths ahead of the midpoint
      assign glt_tick[i] = half - WIN_W'(GLT_EDGES - 1 - i) * t_eff;
      assign glt_rise[i] = ((i % 2) == 0) ? EDGE_RISE : EDGE_FALL;
      assign glt_vld[i]  = 1'b1;
    end else begin : g_glt_off
      assign glt_tick[i] = '0;
      assign glt_rise[i] = EDGE_FALL;
      assign glt_vld[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/cpg_window_seq.sv
module cpg_window_seq #(
  parameter int unsigned WIN_W = 8,
  parameter int unsigned CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] len_in,
  input  logic [WIN_W-1:0] t_in,
  input  logic [CYC_W-1:0] tgt_in,
  input  logic [WIN_W-1:0] len_eff,
  output logic [WIN_W-1:0] len_q,
  output logic [WIN_W-1:0] t_q,
  output logic             run_q,
  output logic [WIN_W-1:0] tick_q,
  output logic             glitch_sel
);
  // one extra bit so the window counter can step past the largest target
  logic [CYC_W:0]   cyc_q;
  logic [CYC_W-1:0] tgt_q;
  logic             last_tick;

  assign last_tick  = (tick_q == len_eff - WIN_W'(1));
  assign glitch_sel = run_q && (cyc_q == {1'b0, tgt_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      cyc_q  <= '0;
      tgt_q  <= '0;
      len_q  <= '0;
      t_q    <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      tick_q <= '0;
      cyc_q  <= '0;
      tgt_q  <= tgt_in;
      len_q  <= len_in;
      t_q    <= t_in;
    end else if (run_q) begin
      if (last_tick) begin
        tick_q <= '0;
        // stop counting once the target window is behind us
        if (cyc_q <= {1'b0, tgt_q})
          cyc_q <= cyc_q + (CYC_W+1)'(1);
      end else begin
        tick_q <= tick_q + WIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpg_edge_player.sv
module cpg_edge_player #(
  parameter int unsigned WIN_W     = 8,
  parameter int unsigned MAX_EDGES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run,
  input  logic                            mark_in,
  input  logic [WIN_W-1:0]                tick,
  input  logic [MAX_EDGES-1:0][WIN_W-1:0] e_tick,
  input  logic [MAX_EDGES-1:0]            e_rise,
  input  logic [MAX_EDGES-1:0]            e_vld,
  output logic                            clk_q,
  output logic                            mark_q
);
  logic lvl_next;

  always_comb begin
    // every window opens low; edges then set the level
    lvl_next = (tick == '0) ? 1'b0 : clk_q;
    for (int i = MAX_EDGES - 1; i >= 0; i--) begin
      if (e_vld[i] && (tick == e_tick[i]))
        lvl_next = e_rise[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      clk_q  <= run ? lvl_next : 1'b0;
      mark_q <= mark_in;
    end
  end
endmodule

// File: rtl/pulse_window_clkgen.sv
module pulse_window_clkgen #(
  parameter int unsigned WIN_W     = 8,
  parameter int unsigned CYC_W     = 4,
  parameter int unsigned MAX_EDGES = 8,
  parameter int unsigned LEN_MIN   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] pulse_width,
  input  logic [CYC_W-1:0] glitch_cycle,
  output logic             clk_gen,
  output logic             glitch_active
);
  logic [WIN_W-1:0] len_q, t_q, len_eff, half, t_eff, tick_q;
  logic             run_q, glitch_sel;

  logic [MAX_EDGES-1:0][WIN_W-1:0] nrm_tick, glt_tick, sel_tick;
  logic [MAX_EDGES-1:0]            nrm_rise, glt_rise, sel_rise;
  logic [MAX_EDGES-1:0]            nrm_vld,  glt_vld,  sel_vld;

  cpg_window_seq #(.WIN_W(WIN_W), .CYC_W(CYC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_in     (win_len),
    .t_in       (pulse_width),
    .tgt_in     (glitch_cycle),
    .len_eff    (len_eff),
    .len_q      (len_q),
    .t_q        (t_q),
    .run_q      (run_q),
    .tick_q     (tick_q),
    .glitch_sel (glitch_sel)
  );

  cpg_window_composer #(.WIN_W(WIN_W), .MAX_EDGES(MAX_EDGES), .LEN_MIN(LEN_MIN)) u_comp (
    .len_raw  (len_q),
    .t_raw    (t_q),
    .len_eff  (len_eff),
    .half     (half),
    .t_eff    (t_eff),
    .nrm_tick (nrm_tick),
    .nrm_rise (nrm_rise),
    .nrm_vld  (nrm_vld),
    .glt_tick (glt_tick),
    .glt_rise (glt_rise),
    .glt_vld  (glt_vld)
  );

  assign sel_tick = glitch_sel ? glt_tick : nrm_tick;
  assign sel_rise = glitch_sel ? glt_rise : nrm_rise;
  assign sel_vld  = glitch_sel ? glt_vld  : nrm_vld;

  cpg_edge_player #(.WIN_W(WIN_W), .MAX_EDGES(MAX_EDGES)) u_play (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .mark_in (glitch_sel),
    .tick    (tick_q),
    .e_tick  (sel_tick),
    .e_rise  (sel_rise),
    .e_vld   (sel_vld),
    .clk_q   (clk_gen),
    .mark_q  (glitch_active)
  );
endmodule

// File: rtl/pulse_window_clkgen_chk.sv
module pulse_window_clkgen_chk #(
  parameter int unsigned WIN_W   = 8,
  parameter int unsigned LEN_MIN = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             clk_gen,
  input logic             glitch_active,
  input logic             run_q,
  input logic [WIN_W-1:0] len_eff,
  input logic [WIN_W-1:0] half,
  input logic [WIN_W-1:0] t_eff
);
  logic [WIN_W:0] mark_len;
  logic [1:0]     mark_rises;
  logic [2:0]     pulse_rises;
  logic           mark_d, clk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_len    <= '0;
      mark_rises  <= '0;
      pulse_rises <= '0;
      mark_d      <= 1'b0;
      clk_d       <= 1'b0;
    end else begin
      mark_d <= glitch_active;
      clk_d  <= clk_gen;
      if (start) begin
        mark_len    <= '0;
        mark_rises  <= '0;
        pulse_rises <= '0;
      end else begin
        mark_len <= glitch_active ? mark_len + (WIN_W+1)'(1) : '0;
        if (glitch_active && !mark_d && mark_rises != 2'd3)
          mark_rises <= mark_rises + 2'd1;
        if (!glitch_active)
          pulse_rises <= '0;
        else if (clk_gen && !clk_d && pulse_rises != 3'd7)
          pulse_rises <= pulse_rises + 3'd1;
      end
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!clk_gen && !glitch_active));

  // R8
  mark_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_len <= {1'b0, len_eff});

  // R7
  single_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glitch_active && !mark_d && !start) |-> (mark_rises == 2'd0));

  // R4
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_rises <= 3'd3);

  // R5
  width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (t_eff >= WIN_W'(2) && ({2'b00, t_eff} << 2) < {2'b00, half}));

  // R6
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (len_eff >= WIN_W'(LEN_MIN)));
endmodule

bind pulse_window_clkgen pulse_window_clkgen_chk #(.WIN_W(WIN_W), .LEN_MIN(LEN_MIN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .clk_gen       (clk_gen),
  .glitch_active (glitch_active),
  .run_q         (run_q),
  .len_eff       (len_eff),
  .half          (half),
  .t_eff         (t_eff)
);

// File: tb/pulse_window_clkgen_test.sv
module pulse_window_clkgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] win_len = 8'd0;
  logic [7:0] pulse_width = 8'd0;
  logic [3:0] glitch_cycle = 4'd0;
  logic       clk_gen, glitch_active;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pulse_window_clkgen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .win_len       (win_len),
    .pulse_width   (pulse_width),
    .glitch_cycle  (glitch_cycle),
    .clk_gen       (clk_gen),
    .glitch_active (glitch_active)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // arithmetic reference for sample g of a run
  task automatic model(input int l, input int t, input int tgt, input int g,
                       output logic c, output logic m);
    int le, mid, tmx, te, w, k;
    le  = (l < 20) ? 20 : l;
    mid = le / 2;
    tmx = (mid - 1) / 4;
    te  = (t < 2) ? 2 : ((t > tmx) ? tmx : t);
    w   = g / le;
    k   = g % le;
    m   = (w == tgt);
    if (k >= mid) c = 1'b1;
    else if (m && ((k >= mid-4*te && k < mid-3*te) || (k >= mid-2*te && k < mid-te))) c = 1'b1;
    else c = 1'b0;
  endtask

  task automatic pulse_start(input int l, input int t, input int tgt);
    @(negedge clk);
    win_len = 8'(l); pulse_width = 8'(t); glitch_cycle = 4'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // starts a run and checks n samples; at sample chg_at the inputs are disturbed
  task automatic run_case(input int l, input int t, input int tgt, input int n,
                          input int chg_at);
    logic ec, em;
    string tg;
    pulse_start(l, t, tgt);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      model(l, t, tgt, g, ec, em);
      if (chg_at >= 0) tg = "R9";
      else if (l < 20) tg = "R6/R3";
      else if (em && (t < 2 || t > 4)) tg = "R4/R5";
      else if (em) tg = "R4/R2";
      else tg = "R3/R2";
      chk($sformatf("%s clk l=%0d t=%0d tgt=%0d g=%0d", tg, l, t, tgt, g), clk_gen, ec);
      chk($sformatf("R8/R7 mark l=%0d t=%0d tgt=%0d g=%0d", l, t, tgt, g), glitch_active, em);
      if (g == chg_at) begin
        win_len = 8'd90; pulse_width = 8'd13; glitch_cycle = 4'd0;
      end
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1: outputs low in reset and while idle
    repeat (3) @(negedge clk);
    chk("R1 reset clk", clk_gen, 1'b0);
    chk("R1 reset mark", glitch_active, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 idle clk", clk_gen, 1'b0);
      chk("R1 idle mark", glitch_active, 1'b0);
    end

    // sweep of lengths, widths and targets
    foreach (int_list_dummy[i]) ;
    for (int li = 0; li < 6; li++) begin
      int l;
      case (li)
        0: l = 5;  1: l = 20; 2: l = 21;
        3: l = 25; 4: l = 32; default: l = 47;
      endcase
      for (int t = 0; t < 10; t++)
        for (int tgt = 0; tgt < 3; tgt++) begin
          int le;
          le = (l < 20) ? 20 : l;
          run_case(l, t, tgt, le * (tgt + 2), -1);
        end
    end

    // R5: large window, width beyond the upper clamp
    run_case(255, 200, 1, 255 * 3, -1);
    // R7: last possible target index, then windows past it stay normal
    run_case(20, 3, 15, 20 * 18, -1);
    // R9: inputs changed mid-run are ignored
    run_case(24, 3, 2, 24 * 4, 10);
    // R9: restart in the middle of a glitch window
    run_case(30, 2, 0, 9, -1);
    run_case(26, 3, 1, 26 * 3, -1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int int_list_dummy[1];
endmodule